// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind a serial memory front end and handles the write path of a 512-byte nonvolatile array. The front end gives it the opened write frame (start address and target), each received data byte, and the moment chip select is released, together with a flag that says whether that release came exactly on a byte boundary. The controller keeps the bytes in a 16-byte page buffer. The write becomes final only at the release, and only when the release lands cleanly on a byte boundary and the write-enable latch and write-protect pin allow it. It then plays the buffered bytes out to the array as one strobe per written slot. The byte address never leaves the page: bytes past slot 15 wrap to slot 0 and replace what was buffered there.

While the array programs, a busy flag stays high for a fixed number of system clocks set by a parameter. New write frames are refused during that time. A one-cycle completion pulse marks the end. A 2-bit block-protect code, taken at commit, removes writes to a protected upper region of the array, and the rest of the page still commits. A frame aimed at the status register commits its last byte through a separate strobe. That strobe obeys the latch and the pin but not the block-protect code.

Top module: `page_commit_ctrl`

## Requirements
- R1: With `wip` low, a `wr_start` pulse opens a frame. The page is `wr_addr[8:4]` and the first slot is `wr_addr[3:0]`. Each later `byte_vld` stores `byte_data` at the current slot and moves to the next slot. Every committed `mem_addr` keeps `[8:4]` equal to the page and `[3:0]` equal to the slot.
- R2: The slot counter wraps from 15 to 0 within the same page. A byte sent to a slot that already holds data replaces the earlier byte, so a committed frame makes at most 16 array writes.
- R3: A frame commits only if `cs_rise` arrives with `bit_aligned` = 1 and at least one byte stored. Otherwise the frame is discarded with no write and no `wip`. Bytes sent while no frame is open are ignored.
- R4: A commit with `wel` = 0 is discarded, for array and status targets alike.
- R5: A commit with `wp_n` = 0 is discarded, for array and status targets alike.
- R6: `blk_prot` is sampled at commit. 0 protects nothing, 1 protects addresses 0x180–0x1FF, 2 protects 0x100–0x1FF and 3 protects the whole array. Writes to protected slots are dropped and the other slots still write. Even when every slot is dropped, the commit still runs a full `wip` cycle.
- R7: A frame opened with `wr_status` = 1 commits through `st_we` / `st_wdata`, carrying the last byte received. This path ignores `blk_prot` and never drives `mem_we`.
- R8: After a commit, `wip` is high for exactly `WCYC` cycles. All `mem_we` / `st_we` strobes fall inside that window, with at most one strobe per slot, in ascending slot order.
- R9: `done` is a one-cycle pulse in the first cycle after `wip` falls. It pulses once per commit and never for a discarded frame.
- R10: A `wr_start` while `wip` is high is refused. That frame's bytes and its release cause no write and no new `wip` cycle.
- R11: After reset `wip`, `done`, `mem_we` and `st_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Opens a write frame (one-cycle pulse) |
| wr_addr | input | 9 | Start byte address of the frame |
| wr_status | input | 1 | 1: frame targets the status register |
| byte_vld | input | 1 | One complete data byte is present |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select released (one-cycle pulse) |
| bit_aligned | input | 1 | Release came right after bit 0 of a byte |
| wel | input | 1 | Write-enable latch level |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| blk_prot | input | 2 | Block-protect code |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| st_we | output | 1 | Status register write strobe |
| st_wdata | output | 8 | Status register write data |
| wip | output | 1 | Nonvolatile write in progress |
| done | output | 1 | Write cycle complete pulse |

## Verification
The hardest case to reach from the ports is a frame that starts during a write cycle. It must be refused completely, yet it looks exactly like a valid frame. The bench opens a full, aligned and enabled frame in the cycles just after a commit, while `wip` is high. It then watches long enough after `done` to catch any stray strobe or a second busy window. The page wrap gets the same treatment: twenty bytes are sent so that four slots are overwritten, and each strobed byte is compared with the last value aimed at its slot.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2
    } pcc_state_e;

    typedef enum logic [1:0] {
        LOCK_NONE    = 2'd0,
        LOCK_QUARTER = 2'd1,
        LOCK_HALF    = 2'd2,
        LOCK_ALL     = 2'd3
    } lock_code_e;
endpackage

// File: rtl/pcc_region_guard.sv
module pcc_region_guard
    import pcc_pkg::*;
(
    input  logic [1:0] lock_code,
    input  logic [1:0] addr_top,
    output logic       locked
);
    always_comb begin
        unique case (lock_code_e'(lock_code))
            LOCK_NONE:    locked = 1'b0;
            LOCK_QUARTER: locked = (addr_top == 2'b11);
            LOCK_HALF:    locked = addr_top[1];
            default:      locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pcc_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 8,
    parameter int PG_BITS = 4,
    parameter int WCYC    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_status,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              bit_aligned,
    input  logic              wel,
    input  logic              wp_n,
    input  logic [1:0]        blk_prot,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              st_we,
    output logic [DATA_W-1:0] st_wdata,
    output logic              wip,
    output logic              done
);
    localparam int PAGE   = 1 << PG_BITS;
    localparam int PGN_W  = ADDR_W - PG_BITS;
    localparam int SPAN   = (WCYC > PAGE) ? WCYC : PAGE;
    localparam int CNT_W  = $clog2(SPAN) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WCYC - 1);
    localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE);

    typedef struct packed {
        pcc_state_e                   st;
        logic [PGN_W-1:0]             page;
        logic [PG_BITS-1:0]           slot;
        logic [PAGE-1:0]              held;
        logic [PAGE-1:0][DATA_W-1:0]  dat;
        logic                         to_status;
        logic [DATA_W-1:0]            last;
        logic [1:0]                   lock;
        logic [CNT_W-1:0]             cnt;
        logic                         done;
    } pcc_reg_t;

    pcc_reg_t r_q, r_d;

    logic [PG_BITS-1:0] out_slot;
    logic               in_burst;
    logic               slot_locked;

    assign out_slot = r_q.cnt[PG_BITS-1:0];
    assign in_burst = (r_q.cnt < CNT_PAGE);

    pcc_region_guard u_guard (
        .lock_code (r_q.lock),
        .addr_top  (r_q.page[PGN_W-1 -: 2]),
        .locked    (slot_locked)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (wr_start) begin
                    r_d.st        = ST_FILL;
                    r_d.page      = wr_addr[ADDR_W-1:PG_BITS];
                    r_d.slot      = wr_addr[PG_BITS-1:0];
                    r_d.held      = '0;
                    r_d.to_status = wr_status;
                end
            end
            ST_FILL: begin
                if (cs_rise) begin
                    if (bit_aligned && (|r_q.held) && wel && wp_n) begin
                        r_d.st   = ST_PROG;
                        r_d.cnt  = '0;
                        r_d.lock = blk_prot;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else if (byte_vld) begin
                    r_d.dat[r_q.slot]  = byte_data;
                    r_d.held[r_q.slot] = 1'b1;
                    r_d.slot           = r_q.slot + 1'b1;
                    r_d.last           = byte_data;
                end
            end
            ST_PROG: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wip       = (r_q.st == ST_PROG);
    assign mem_we    = wip && !r_q.to_status && in_burst && r_q.held[out_slot] && !slot_locked;
    assign mem_addr  = {r_q.page, out_slot};
    assign mem_wdata = r_q.dat[out_slot];
    assign st_we     = wip && r_q.to_status && (r_q.cnt == '0);
    assign st_wdata  = r_q.last;
    assign done      = r_q.done;

    AST_WIP_NEEDS_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise && bit_aligned && wel && wp_n)) else $error("commit without clean release"); // R3
    AST_STROBE_IN_WIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || st_we) |-> wip) else $error("write strobe outside wip"); // R8
    AST_DONE_AFTER_WIP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wip && $past(wip))) else $error("done not after wip"); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R9
    AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> $stable(mem_addr[ADDR_W-1:PG_BITS])) else $error("page moved"); // R1
    AST_NO_WRITE_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && r_q.lock == LOCK_ALL) |-> !mem_we) else $error("write to locked array"); // R6
    AST_TARGET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && st_we)) else $error("both targets strobed"); // R7
endmodule

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;
    localparam int WCYC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0;
    logic [8:0] wr_addr = '0;
    logic       wr_status = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cs_rise = 1'b0;
    logic       bit_aligned = 1'b0;
    logic       wel = 1'b0;
    logic       wp_n = 1'b0;
    logic [1:0] blk_prot = '0;
    logic       mem_we, st_we, wip, done;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata, st_wdata;

    always #2.5 clk = ~clk;

    page_commit_ctrl #(.WCYC(WCYC)) u_page_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_status(wr_status), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_rise(cs_rise), .bit_aligned(bit_aligned), .wel(wel), .wp_n(wp_n),
        .blk_prot(blk_prot), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .st_we(st_we), .st_wdata(st_wdata),
        .wip(wip), .done(done)
    );

    typedef struct packed {
        logic [8:0] addr;
        logic [4:0] n;
        logic       al;
        logic       en;
        logic       pin;
        logic [1:0] bp;
        logic       kind;
        logic       commit;
        logic [4:0] exp_cnt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{9'h010, 5'd1,  1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 5'd1,  4'd1},
        '{9'h025, 5'd4,  1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 5'd4,  4'd1},
        '{9'h03E, 5'd4,  1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 5'd4,  4'd2},
        '{9'h040, 5'd20, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 5'd16, 4'd2},
        '{9'h050, 5'd3,  1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0,  4'd3},
        '{9'h060, 5'd2,  1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0,  4'd4},
        '{9'h070, 5'd2,  1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0,  4'd5},
        '{9'h180, 5'd3,  1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 5'd0,  4'd6},
        '{9'h100, 5'd3,  1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 5'd3,  4'd6},
        '{9'h100, 5'd3,  1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 5'd0,  4'd6},
        '{9'h000, 5'd2,  1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 5'd0,  4'd6},
        '{9'h17E, 5'd2,  1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 5'd2,  4'd6},
        '{9'h000, 5'd1,  1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 5'd1,  4'd7},
        '{9'h000, 5'd1,  1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 5'd0,  4'd7},
        '{9'h090, 5'd0,  1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0,  4'd3}
    };

    int checks = 0;
    int fails  = 0;

    int         n_mem, n_st, n_wip, n_done;
    logic [15:0] seen;
    logic [7:0]  seen_dat [16];
    logic [8:0]  seen_adr [16];
    logic [7:0]  st_seen;
    int          last_slot;
    logic        order_ok;

    function automatic string rq(input logic [3:0] c);
        case (c)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R?";
        endcase
    endfunction

    function automatic logic [7:0] pat(input int v, input int j);
        return 8'((v * 16 + j * 5 + 7) & 255);
    endfunction

    function automatic logic prot(input logic [1:0] bp, input logic [8:0] a);
        case (bp)
            2'd0: return 1'b0;
            2'd1: return a >= 9'h180;
            2'd2: return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_mem = 0; n_st = 0; n_wip = 0; n_done = 0;
        seen = '0; last_slot = -1; order_ok = 1'b1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                n_mem++;
                if (int'(mem_addr[3:0]) <= last_slot) order_ok = 1'b0;
                last_slot = int'(mem_addr[3:0]);
                seen[mem_addr[3:0]]     = 1'b1;
                seen_dat[mem_addr[3:0]] = mem_wdata;
                seen_adr[mem_addr[3:0]] = mem_addr;
            end
            if (st_we) begin n_st++; st_seen = st_wdata; end
            if (wip) n_wip++;
            if (done) n_done++;
        end
    end

    task automatic frame(input logic [8:0] a, input int n, input logic kind, input int v,
                         input logic al, input logic en, input logic pin, input logic [1:0] bp);
        @(negedge clk);
        wr_start = 1'b1; wr_addr = a; wr_status = kind;
        @(negedge clk);
        wr_start = 1'b0;
        for (int j = 0; j < n; j++) begin
            byte_vld = 1'b1; byte_data = pat(v, j);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        cs_rise = 1'b1; bit_aligned = al; wel = en; wp_n = pin; blk_prot = bp;
        @(negedge clk);
        cs_rise = 1'b0;
    endtask

    task automatic settle();
        for (int k = 0; k < WCYC + 6; k++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        check("R11", !wip && !done && !mem_we && !st_we, int'({wip, done, mem_we, st_we}), 0, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", !wip && !done && !mem_we && !st_we, int'({wip, done, mem_we, st_we}), 0, "after reset");

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [7:0] ed [16];
            logic [15:0] eh;
            string r;
            t = VEC[v];
            r = rq(t.req);
            clear_mon();
            eh = '0;
            for (int j = 0; j < int'(t.n); j++) begin
                eh[(int'(t.addr[3:0]) + j) % 16] = 1'b1;
                ed[(int'(t.addr[3:0]) + j) % 16] = pat(v, j);
            end
            frame(t.addr, int'(t.n), t.kind, v, t.al, t.en, t.pin, t.bp);
            settle();
            if (t.kind)
                check(r, n_st == int'(t.exp_cnt) && n_mem == 0, n_st, int'(t.exp_cnt), "status strobes");
            else
                check(r, n_mem == int'(t.exp_cnt) && n_st == 0, n_mem, int'(t.exp_cnt), "array strobes");
            check("R8", n_wip == (t.commit ? WCYC : 0), n_wip, t.commit ? WCYC : 0, "wip length");
            check("R9", n_done == int'(t.commit), n_done, int'(t.commit), "done pulses");
            check("R8", order_ok, int'(order_ok), 1, "ascending slots");
            if (t.kind && n_st > 0)
                check("R7", st_seen == pat(v, int'(t.n) - 1), int'(st_seen), int'(pat(v, int'(t.n) - 1)), "status data");
            for (int s = 0; s < 16; s++) begin
                if (seen[s]) begin
                    logic [8:0] ea;
                    ea = {t.addr[8:4], 4'(s)};
                    check(r, eh[s] && !prot(t.bp, ea), int'(seen_adr[s]), int'(ea), "strobe on expected slot");
                    check("R1", seen_adr[s] == ea, int'(seen_adr[s]), int'(ea), "address page/slot");
                    check("R2", seen_dat[s] == ed[s], int'(seen_dat[s]), int'(ed[s]), "slot data");
                end
            end
        end

        // R10: a frame opened during wip is refused
        clear_mon();
        frame(9'h020, 1, 1'b0, 40, 1'b1, 1'b1, 1'b1, 2'd0);
        frame(9'h0A0, 2, 1'b0, 41, 1'b1, 1'b1, 1'b1, 2'd0);
        settle(); settle();
        check("R10", n_mem == 1, n_mem, 1, "writes with frame during wip");
        check("R10", n_wip == WCYC, n_wip, WCYC, "single wip window");
        check("R10", n_done == 1, n_done, 1, "single done");

        // R3: bytes and release with no open frame do nothing
        clear_mon();
        @(negedge clk);
        byte_vld = 1'b1; byte_data = 8'h5A;
        @(negedge clk);
        byte_vld = 1'b0; cs_rise = 1'b1; bit_aligned = 1'b1; wel = 1'b1; wp_n = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        settle();
        check("R3", n_mem == 0 && n_wip == 0, n_mem + n_wip, 0, "bytes without frame");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule